// File: doc/BRIEF.md
# ATM25 Transmit Convergence Framer

This block turns a stream of 53-byte ATM cells into the serial line signal of a 25.6 Mbps copper link. It runs on the line-rate bit clock and pulls cell bytes from a FIFO that presents its head byte on `cell_data`. Each cell is announced by a two-symbol command. Cell bytes are scrambled one nibble at a time, high nibble first. Every nibble is mapped to a 5-bit symbol. The symbols are shifted out MSB first, and the resulting bit stream is NRZI coded onto `line_out`.

Work is done in pairs of symbols: one octet, either a command or a scrambled cell byte. At the start of each pair the block picks what to send. A pending 8 kHz timing marker wins over everything else. Next comes the rest of a cell already in progress. After that, a new cell's start command when a full cell is waiting. Otherwise an idle command is sent. A sync pulse is therefore honoured at the next octet boundary, even in the middle of a cell. The cell then continues where it stopped, and its scrambler sequence is unbroken.

Top module: `atm25_tx_framer`

## Requirements
- R1: Nibble-to-symbol map (hex): 0→1E, 1→09, 2→14, 3→15, 4→0A, 5→0B, 6→0E, 7→0F, 8→12, 9→13, A→16, B→17, C→1A, D→1B, E→1C, F→1D. The escape symbol is 18.
- R2: Each 5-bit symbol goes out MSB first, one bit per clock, with no gaps between symbols. `line_out` toggles in the clock after a 1 bit and holds after a 0 bit.
- R3: A command is the escape symbol followed by a second symbol, and neither is scrambled. The four commands are: start-with-reseed (escape, escape), start-without-reseed (escape, symbol of 4), timing marker (escape, symbol of 8) and idle (escape, symbol of 0).
- R4: `cell_avail` high means a complete cell is stored. A start command begins a cell of exactly 53 bytes. `cell_rd` is high for one cycle per byte, in the cycle whose clock edge loads that byte's first symbol, and `cell_data` is used in that cycle.
- R5: `scr_reset_sel`, sampled when a start command is chosen, selects start-with-reseed (1) or start-without-reseed (0).
- R6: The scrambler is a 10-bit register s with initial state all ones. On each step, f = s[9] XOR s[6] is output and s becomes {s[8:0], f}. Four steps make one nibble, with the first step giving its MSB. Each byte XORs the high nibble with the first keystream nibble and the low nibble with the second. The register advances only for cell bytes.
- R7: Start-with-reseed returns the scrambler to all ones before the cell's first byte. Start-without-reseed leaves it running.
- R8: A `sync_pulse` is remembered until sent. At the next pair boundary, counting a boundary in the same cycle as the pulse, a timing marker goes out ahead of cell bytes and start commands. An interrupted cell then resumes with its next byte.
- R9: Several sync pulses arriving before the marker is sent produce a single marker.
- R10: With no cell in progress and `cell_avail` low, idle commands are sent back to back.
- R11: During reset `line_out` and `cell_rd` are 0. After reset, one 0 bit is sent before the first symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pulse | input | 1 | 8 kHz timing reference, one-cycle pulse |
| scr_reset_sel | input | 1 | 1: next cell starts with scrambler reseed |
| cell_avail | input | 1 | At least one complete cell is in the FIFO |
| cell_data | input | 8 | Head byte of the cell FIFO |
| cell_rd | output | 1 | Pops the FIFO head byte this cycle |
| line_out | output | 1 | NRZI coded serial line |

## Verification
The bench runs idle periods, cells of all-zero bytes and cells of all-ones bytes. All-zero bytes expose the bare keystream; all-ones bytes expose its complement. It also sends cells whose bytes count upward, so every nibble symbol appears. Cells are started with and without reseed, and back-to-back cells show whether the scrambler continues across a start-without-reseed. Sync pulses are placed at every bit phase of a pair, inside cells and during idle, and in closely spaced groups. These separate a marker sent at an octet boundary from one sent mid-octet, from one sent late and from one sent twice.

// File: rtl/atm25_tx_pkg.sv
`timescale 1ns/1ps
package atm25_tx_pkg;

  localparam int SYM_W  = 5;
  localparam int LFSR_W = 10;
  localparam int TAP_HI = LFSR_W - 1;
  localparam int TAP_LO = 6;
  localparam int KEY_W  = 8;

  localparam logic [SYM_W-1:0] SYM_ESC   = 5'h18;
  localparam logic [3:0]       NIB_MARK  = 4'h8;
  localparam logic [3:0]       NIB_KEEP  = 4'h4;
  localparam logic [3:0]       NIB_IDLE  = 4'h0;

  typedef enum logic [2:0] {
    PK_MARK,
    PK_DATA,
    PK_XX,
    PK_X4,
    PK_IDLE
  } pair_kind_e;

  function automatic logic [SYM_W-1:0] sym_of(input logic [3:0] nib);
    logic [SYM_W-1:0] s;
    case (nib)
      4'h0: s = 5'h1E;
      4'h1: s = 5'h09;
      4'h2: s = 5'h14;
      4'h3: s = 5'h15;
      4'h4: s = 5'h0A;
      4'h5: s = 5'h0B;
      4'h6: s = 5'h0E;
      4'h7: s = 5'h0F;
      4'h8: s = 5'h12;
      4'h9: s = 5'h13;
      4'hA: s = 5'h16;
      4'hB: s = 5'h17;
      4'hC: s = 5'h1A;
      4'hD: s = 5'h1B;
      4'hE: s = 5'h1C;
      default: s = 5'h1D;
    endcase
    return s;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  function automatic logic [KEY_W-1:0] lfsr_key(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    logic [KEY_W-1:0]  k;
    t = s;
    k = '0;
    for (int i = 0; i < KEY_W; i++) begin
      k[KEY_W-1-i] = t[TAP_HI] ^ t[TAP_LO];
      t = lfsr_next(t);
    end
    return k;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_jump(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < KEY_W; i++) t = lfsr_next(t);
    return t;
  endfunction

endpackage

// File: rtl/atm25_tx_scrambler.sv
`timescale 1ns/1ps
module atm25_tx_scrambler
  import atm25_tx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reseed,
  input  logic             adv,
  output logic [KEY_W-1:0] key
);

  logic [LFSR_W-1:0] state_q;

  assign key = lfsr_key(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SEED;
    else if (reseed) state_q <= SEED;
    else if (adv)    state_q <= lfsr_jump(state_q);
  end

endmodule

// File: rtl/atm25_tx_serializer.sv
`timescale 1ns/1ps
module atm25_tx_serializer
  import atm25_tx_pkg::*;
#(
  parameter int W = SYM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] next_sym,
  output logic         load,
  output logic         tx_bit,
  output logic         line_out
);

  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] bc_q;
  logic [W-1:0]     sh_q;
  logic             line_q;

  assign load     = (bc_q == LAST);
  assign tx_bit   = sh_q[W-1];
  assign line_out = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q   <= LAST;
      sh_q   <= '0;
      line_q <= 1'b0;
    end else begin
      line_q <= line_q ^ tx_bit;
      if (load) begin
        sh_q <= next_sym;
        bc_q <= '0;
      end else begin
        sh_q <= {sh_q[W-2:0], 1'b0};
        bc_q <= bc_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/atm25_tx_sequencer.sv
`timescale 1ns/1ps
module atm25_tx_sequencer
  import atm25_tx_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int REM_W = $clog2(CELL_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             sync_pulse,
  input  logic             scr_reset_sel,
  input  logic             cell_avail,
  input  logic [7:0]       cell_data,
  input  logic [KEY_W-1:0] key,
  output logic [SYM_W-1:0] next_sym,
  output logic             cell_rd,
  output logic             reseed,
  output logic             adv,
  output logic             pair_start,
  output logic             pend_q,
  output logic [REM_W-1:0] rem_q
);

  logic             half_q;
  logic [SYM_W-1:0] sym2_q;
  logic             mark_due;
  pair_kind_e       kind;
  logic [SYM_W-1:0] first_sym;
  logic [SYM_W-1:0] second_sym;

  assign pair_start = load & ~half_q;
  assign mark_due   = pend_q | sync_pulse;

  always_comb begin
    if (mark_due)                kind = PK_MARK;
    else if (rem_q != '0)        kind = PK_DATA;
    else if (cell_avail)         kind = scr_reset_sel ? PK_XX : PK_X4;
    else                         kind = PK_IDLE;
  end

  always_comb begin
    first_sym  = SYM_ESC;
    second_sym = sym_of(NIB_IDLE);
    case (kind)
      PK_MARK: second_sym = sym_of(NIB_MARK);
      PK_DATA: begin
        first_sym  = sym_of(cell_data[7:4] ^ key[7:4]);
        second_sym = sym_of(cell_data[3:0] ^ key[3:0]);
      end
      PK_XX:   second_sym = SYM_ESC;
      PK_X4:   second_sym = sym_of(NIB_KEEP);
      default: second_sym = sym_of(NIB_IDLE);
    endcase
  end

  assign next_sym = pair_start ? first_sym : sym2_q;
  assign cell_rd  = pair_start & (kind == PK_DATA);
  assign adv      = cell_rd;
  assign reseed   = pair_start & (kind == PK_XX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      sym2_q <= '0;
      pend_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      if (load) half_q <= ~half_q;
      if (pair_start) begin
        sym2_q <= second_sym;
        pend_q <= 1'b0;
        case (kind)
          PK_DATA:      rem_q <= rem_q - REM_W'(1);
          PK_XX, PK_X4: rem_q <= REM_W'(CELL_BYTES);
          default:      rem_q <= rem_q;
        endcase
      end else begin
        pend_q <= mark_due;
      end
    end
  end

endmodule

// File: rtl/atm25_tx_framer.sv
`timescale 1ns/1ps
module atm25_tx_framer
  import atm25_tx_pkg::*;
#(
  parameter int                CELL_BYTES = 53,
  parameter logic [LFSR_W-1:0] SEED       = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_pulse,
  input  logic       scr_reset_sel,
  input  logic       cell_avail,
  input  logic [7:0] cell_data,
  output logic       cell_rd,
  output logic       line_out
);

  localparam int REM_W = $clog2(CELL_BYTES + 1);

  logic             load;
  logic             tx_bit;
  logic [SYM_W-1:0] next_sym;
  logic [KEY_W-1:0] key;
  logic             reseed;
  logic             adv;
  logic             pair_start;
  logic             pend_q;
  logic [REM_W-1:0] rem_q;

  atm25_tx_sequencer #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .sync_pulse   (sync_pulse),
    .scr_reset_sel(scr_reset_sel),
    .cell_avail   (cell_avail),
    .cell_data    (cell_data),
    .key          (key),
    .next_sym     (next_sym),
    .cell_rd      (cell_rd),
    .reseed       (reseed),
    .adv          (adv),
    .pair_start   (pair_start),
    .pend_q       (pend_q),
    .rem_q        (rem_q)
  );

  atm25_tx_scrambler #(.SEED(SEED)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .reseed(reseed),
    .adv   (adv),
    .key   (key)
  );

  atm25_tx_serializer #(.W(SYM_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .next_sym(next_sym),
    .load    (load),
    .tx_bit  (tx_bit),
    .line_out(line_out)
  );

endmodule

// File: rtl/atm25_tx_checker.sv
`timescale 1ns/1ps
module atm25_tx_checker #(
  parameter int CELL_BYTES = 53,
  localparam int REM_W = $clog2(CELL_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             pair_start,
  input logic             pend_q,
  input logic             sync_pulse,
  input logic             scr_reset_sel,
  input logic             cell_avail,
  input logic             cell_rd,
  input logic             reseed,
  input logic [REM_W-1:0] rem_q,
  input logic             tx_bit,
  input logic             line_out
);

  AST_LINE_HOLDS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |=> $stable(line_out)); // R2
  AST_LINE_FLIPS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit |=> (line_out != $past(line_out))); // R2
  AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load); // R2
  AST_READ_AT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cell_rd |-> pair_start); // R4
  AST_CELL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_start && !pend_q && !sync_pulse && rem_q == '0 && cell_avail)
      |=> (rem_q == REM_W'(CELL_BYTES))); // R4
  AST_SEL_PICKS_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_start && !pend_q && !sync_pulse && rem_q == '0 && cell_avail)
      |-> (reseed == scr_reset_sel)); // R5
  AST_MARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_start && (pend_q || sync_pulse)) |-> (!cell_rd && !reseed)); // R8
  AST_MARK_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_start && (pend_q || sync_pulse)) |=> !pend_q); // R9
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> !cell_rd); // R10

endmodule

bind atm25_tx_framer atm25_tx_checker #(.CELL_BYTES(CELL_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load         (load),
  .pair_start   (pair_start),
  .pend_q       (pend_q),
  .sync_pulse   (sync_pulse),
  .scr_reset_sel(scr_reset_sel),
  .cell_avail   (cell_avail),
  .cell_rd      (cell_rd),
  .reseed       (reseed),
  .rem_q        (rem_q),
  .tx_bit       (tx_bit),
  .line_out     (line_out)
);

// File: tb/sim_atm25_tx_framer.sv
`timescale 1ns/1ps
module sim_atm25_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_pulse = 1'b0;
  logic       scr_reset_sel = 1'b0;
  logic       cell_avail = 1'b0;
  logic [7:0] cell_data = 8'h00;
  logic       cell_rd;
  logic       line_out;

  always #2.5 clk = ~clk;

  atm25_tx_framer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_pulse   (sync_pulse),
    .scr_reset_sel(scr_reset_sel),
    .cell_avail   (cell_avail),
    .cell_data    (cell_data),
    .cell_rd      (cell_rd),
    .line_out     (line_out)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R11";

  // reference model state
  int         q_bits[$];
  logic [7:0] fifo[$];
  bit         m_line = 1'b0;
  bit         m_pend = 1'b0;
  int         m_rem = 0;
  int         m_scr = 1023;
  int         rd_seen = 0;
  int         bytes_pushed = 0;
  bit         sel_v = 1'b0;

  // R1 table, written independently
  int sym_tab[16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};
  localparam int ESC = 24;

  task automatic put_sym(input int v);
    for (int i = 4; i >= 0; i--) q_bits.push_back((v >> i) & 1);
  endtask

  // R6: keystream nibble, four register steps, first step is the MSB
  function automatic int key_nib();
    int n = 0;
    for (int i = 0; i < 4; i++) begin
      int f = ((m_scr >> 9) ^ (m_scr >> 6)) & 1;
      n = (n << 1) | f;
      m_scr = ((m_scr << 1) | f) & 1023;
    end
    return n;
  endfunction

  task automatic note_fail(input string what, input int got, input int exp);
    errors++;
    $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
  endtask

  // one clock: drive, check read strobe, advance model, compare line
  task automatic step(input bit sy);
    bit avail_now;
    int exp_rd;
    int b;
    avail_now     = (fifo.size() >= 53);
    sync_pulse    = sy;
    scr_reset_sel = sel_v;
    cell_avail    = avail_now;
    cell_data     = (fifo.size() > 0) ? fifo[0] : 8'h00;
    #1;
    exp_rd = 0;
    b = q_bits.pop_front();
    m_line = m_line ^ b[0];
    if (sy) m_pend = 1'b1;
    if (q_bits.size() == 0) begin
      if (m_pend) begin // R8 marker: escape, symbol of 8
        m_pend = 1'b0;
        put_sym(ESC); put_sym(sym_tab[8]);
      end else if (m_rem > 0) begin // R4 data byte
        logic [7:0] d;
        int h, l;
        d = fifo.pop_front();
        h = key_nib();
        l = key_nib();
        put_sym(sym_tab[d[7:4] ^ h[3:0]]);
        put_sym(sym_tab[d[3:0] ^ l[3:0]]);
        m_rem--;
        exp_rd = 1;
      end else if (avail_now) begin // R5 / R7
        if (sel_v) begin put_sym(ESC); put_sym(ESC); m_scr = 1023; end
        else begin put_sym(ESC); put_sym(sym_tab[4]); end
        m_rem = 53;
      end else begin // R10 idle
        put_sym(ESC); put_sym(sym_tab[0]);
      end
    end
    checks++;
    if (cell_rd !== exp_rd[0]) note_fail("cell_rd", cell_rd, exp_rd);
    if (cell_rd === 1'b1) rd_seen++;
    @(negedge clk);
    checks++;
    if (line_out !== m_line) note_fail("line_out", line_out, m_line);
  endtask

  task automatic run(input int n, input int sync_at);
    for (int i = 0; i < n; i++) step(i == sync_at);
  endtask

  task automatic push_cell(input int kind);
    for (int j = 0; j < 53; j++) begin
      case (kind)
        0: fifo.push_back(8'h00);
        1: fifo.push_back(8'hFF);
        default: fifo.push_back(8'(j * 5 + 16));
      endcase
      bytes_pushed++;
    end
  endtask

  initial begin
    q_bits.push_back(0); // R11 leading zero bit
    repeat (3) @(negedge clk);
    tag = "R11";
    checks++;
    if (line_out !== 1'b0) note_fail("reset line_out", line_out, 0);
    checks++;
    if (cell_rd !== 1'b0) note_fail("reset cell_rd", cell_rd, 0);
    rst_n = 1'b1;

    tag = "R10"; run(60, -1);          // idle commands only
    tag = "R3";  run(40, 13);          // marker during idle
    tag = "R7";  sel_v = 1; push_cell(0); run(600, -1); // reseed, bare keystream
    tag = "R5";  sel_v = 0; push_cell(1); push_cell(0); run(1200, -1); // continue keystream
    tag = "R1";  sel_v = 1; push_cell(2); run(600, -1); // counting bytes
    tag = "R8";  sel_v = 1; push_cell(2); run(600, 137); // marker mid cell
    for (int k = 0; k < 10; k++) begin // every bit phase of a pair
      tag = "R8"; sel_v = k[0]; push_cell(k % 3); run(600, 200 + k);
    end
    tag = "R9"; run(20, 2); run(3, 1); run(60, -1); // pulses close together
    tag = "R9"; push_cell(2); run(100, 50); run(2, 0); run(600, -1);
    tag = "R6"; sel_v = 0; push_cell(1); push_cell(1); run(1200, -1);
    tag = "R2"; run(50, -1);

    tag = "R4";
    checks++;
    if (rd_seen != bytes_pushed) note_fail("bytes read", rd_seen, bytes_pushed);
    checks++;
    if (fifo.size() != 0) note_fail("bytes left", fifo.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule